// File: doc/BRIEF.md
# Twisted-Ring Counter with Per-State Decoder

This block is an N-bit twisted-ring counter. On each clock edge, every bit moves one place from the most significant end toward the least significant end. The inverted least significant bit enters at the top. The counter visits 2N distinct states and then repeats. A decoder next to it drives 2N state lines, one for each of those states. Every line is formed from exactly two counter bits, so the decoder grows only linearly with the width. The lines are active high by default. A polarity input inverts all of them at once. This suits logic that expects active-low strobes.

Clearing is synchronous and active low. A register pattern that is not one of the 2N legal states can appear after power-up or an upset. Such a pattern is replaced by all zeros on the next clock edge, so the normal sequence resumes.

Top module: `jc_decoded_counter`

## Requirements
- R1: While `clr_n` is low at a rising clock edge, every bit of `cnt` becomes 0 after that edge, whatever it held before. It stays 0 for as long as `clr_n` remains low.
- R2: With `clr_n` high and a legal state in the register, each rising edge does two things. The new `cnt[N-1]` is the inverse of the old `cnt[0]`, and every other bit takes the value of its upper neighbour.
- R3: Starting from all zeros, the counter passes through 2N distinct states and is back at all zeros after exactly 2N edges. For N=4 the order is 0000, 1000, 1100, 1110, 1111, 0111, 0011, 0001.
- R4: The all-zeros state drives line 0, formed as NOT `cnt[N-1]` AND NOT `cnt[0]`. The all-ones state drives line N, formed as `cnt[N-1]` AND `cnt[0]`.
- R5: A state with k ones filled from the top (1 <= k <= N-1) drives line k = `cnt[N-k]` AND NOT `cnt[N-k-1]`. A state with j zeros filled from the top (1 <= j <= N-1) drives line N+j = NOT `cnt[N-j]` AND `cnt[N-j-1]`. So the second state after a clear, a single 1 at the top, always drives line 1.
- R6: In every legal state exactly one state line is asserted.
- R7: With `pol_low` = 0 an asserted line reads 1. With `pol_low` = 1 every line is inverted, so the asserted line reads 0 and all others read 1. The change takes effect without a clock edge.
- R8: A legal state has at most one adjacent bit pair that differs. Any pattern with more than one such pair is illegal. An illegal pattern, with `clr_n` high, becomes all zeros at the next edge. Legal patterns are never redirected.
- R9: `dec` is a combinational function of `cnt` and `pol_low`. It changes in the same cycle as `cnt`, with no added register stage, and holds steady while neither input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low |
| pol_low | input | 1 | 0: state lines active high; 1: active low |
| cnt | output | WIDTH | Registered counter bits |
| dec | output | 2*WIDTH | Decoded state lines; index k marks the k-th state after all zeros |

## Verification
The hardest condition to create is an illegal register pattern. No port can load arbitrary data, and clear and counting only ever produce legal states. The stimulus overrides the counter register with a chosen value between clock edges, then releases it. It then watches the ports to confirm that the next edge returns all zeros and that counting resumes.

Two further cases use the same override. A forced legal mid-sequence pattern checks that the recovery logic never redirects a good state. A forced illegal pattern applied during a clear checks that the clear wins.

// File: rtl/jc_pkg.sv
package jc_pkg;

    // Polarity of the decoded state lines.
    typedef enum logic {
        POL_HIGH = 1'b0,
        POL_LOW  = 1'b1
    } line_pol_e;

    // Number of states (and decode lines) of a twisted ring of the given width.
    function automatic int unsigned line_count(input int unsigned width);
        return 2 * width;
    endfunction

endpackage

// File: rtl/jc_ring.sv
module jc_ring #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    output logic [WIDTH-1:0] bits,
    output logic             legal
);
    localparam int unsigned PAIRS = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } ring_t;

    ring_t            ring_d;
    ring_t            ring_q;
    logic [PAIRS-1:0] edge_mark;

    // Next state: clear wins, then recovery from an illegal pattern, then the twisted shift.
    always_comb begin
        edge_mark = ring_q.bits[WIDTH-1:1] ^ ring_q.bits[WIDTH-2:0];
        legal     = (edge_mark & (edge_mark - 1'b1)) == '0;
        ring_d    = ring_q;
        if (!clr_n) begin
            ring_d.bits = '0;
        end else if (!legal) begin
            ring_d.bits = '0;
        end else begin
            ring_d.bits = {~ring_q.bits[0], ring_q.bits[WIDTH-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        ring_q <= ring_d;
    end

    assign bits = ring_q.bits;

endmodule

// File: rtl/jc_decode.sv
module jc_decode #(
    parameter int unsigned WIDTH = 4
) (
    input  logic                          pol_low,
    input  logic [WIDTH-1:0]              bits,
    output logic [jc_pkg::line_count(WIDTH)-1:0] dec
);
    localparam int unsigned LINES = jc_pkg::line_count(WIDTH);

    logic [LINES-1:0] line_hi;

    generate
        for (genvar k = 0; k < LINES; k++) begin : g_line
            if (k == 0) begin : g_zero
                assign line_hi[k] = ~bits[WIDTH-1] & ~bits[0];
            end else if (k == WIDTH) begin : g_ones
                assign line_hi[k] = bits[WIDTH-1] & bits[0];
            end else if (k < WIDTH) begin : g_fill1
                localparam int unsigned HI = WIDTH - k;
                assign line_hi[k] = bits[HI] & ~bits[HI-1];
            end else begin : g_fill0
                localparam int unsigned HI = 2 * WIDTH - k;
                assign line_hi[k] = ~bits[HI] & bits[HI-1];
            end
        end
    endgenerate

    assign dec = (pol_low == jc_pkg::POL_LOW) ? ~line_hi : line_hi;

    // R4: the two uniform states each select their own end-bit line.
    always_comb begin
        if (bits == '0) begin
            a_r4_zero_line: assert (line_hi[0] && !line_hi[WIDTH]);
        end
        if (bits == '1) begin
            a_r4_ones_line: assert (line_hi[WIDTH] && !line_hi[0]);
        end
    end

endmodule

// File: rtl/jc_decoded_counter.sv
module jc_decoded_counter #(
    parameter int unsigned WIDTH = 4
) (
    input  logic                                 clk,
    input  logic                                 clr_n,
    input  logic                                 pol_low,
    output logic [WIDTH-1:0]                     cnt,
    output logic [jc_pkg::line_count(WIDTH)-1:0] dec
);
    localparam int unsigned LINES = jc_pkg::line_count(WIDTH);

    logic ring_legal;

    jc_ring #(.WIDTH(WIDTH)) u_ring (
        .clk   (clk),
        .clr_n (clr_n),
        .bits  (cnt),
        .legal (ring_legal)
    );

    jc_decode #(.WIDTH(WIDTH)) u_dec (
        .pol_low (pol_low),
        .bits    (cnt),
        .dec     (dec)
    );

    // R1: a clear sampled at an edge leaves all bits at zero.
    a_r1_clear_zero: assert property (@(posedge clk)
        !clr_n |=> cnt == '0);

    // R8: more than one differing neighbour pair is replaced by zeros.
    a_r8_recover: assert property (@(posedge clk) disable iff (!clr_n)
        ($countones(cnt[WIDTH-1:1] ^ cnt[WIDTH-2:0]) > 1) |=> cnt == '0);

    // R8: the ring's own legality flag agrees with an independent pair count.
    a_r8_legal_flag: assert property (@(posedge clk) disable iff (!clr_n)
        ring_legal == ($countones(cnt[WIDTH-1:1] ^ cnt[WIDTH-2:0]) <= 1));

    // R5: leaving all zeros, the first step sets only the top bit.
    a_r5_first_step: assert property (@(posedge clk) disable iff (!clr_n)
        (cnt == '0) |=> cnt == {1'b1, {(WIDTH-1){1'b0}}});

    // R6: exactly one line active in any legal state.
    a_r6_one_line: assert property (@(posedge clk) disable iff (!clr_n)
        ($countones(cnt[WIDTH-1:1] ^ cnt[WIDTH-2:0]) <= 1)
        |-> $onehot(pol_low ? ~dec : dec));

    // R7: flipping polarity with the count held inverts every line.
    a_r7_polarity: assert property (@(posedge clk) disable iff (!clr_n)
        ($stable(cnt) && (pol_low != $past(pol_low))) |-> dec == ~$past(dec));

    // R9: no hidden state in the decode path.
    a_r9_no_latency: assert property (@(posedge clk) disable iff (!clr_n)
        ($stable(cnt) && $stable(pol_low)) |-> $stable(dec));

    initial begin
        a_r3_width: assert (WIDTH >= 2 && LINES == 2 * WIDTH);
    end

endmodule

// File: tb/sim_jc_decoded_counter.sv
module sim_jc_decoded_counter;
    localparam int unsigned N     = 8;
    localparam int unsigned LINES = 2 * N;
    localparam int unsigned NROWS = 23;

    // Row: [7] clr_n, [6] pol_low, [5:0] state index expected after the edge.
    localparam logic [7:0] VEC [NROWS] = '{
        8'h00, 8'h81, 8'h82, 8'h83, 8'h84, 8'h85, 8'h86, 8'h87,
        8'h88, 8'h89, 8'h8A, 8'h8B, 8'h8C, 8'h8D, 8'h8E, 8'h8F,
        8'h80, 8'hC1, 8'hC2, 8'h40, 8'hC1, 8'h82, 8'h83
    };

    logic             clk = 1'b0;
    logic             clr_n = 1'b0;
    logic             pol_low = 1'b0;
    logic [N-1:0]     cnt;
    logic [LINES-1:0] dec;
    int               checks = 0;
    int               errors = 0;
    logic             done = 1'b0;

    always #10 clk = ~clk;

    jc_decoded_counter #(.WIDTH(N)) u0 (
        .clk(clk), .clr_n(clr_n), .pol_low(pol_low), .cnt(cnt), .dec(dec)
    );

    function automatic logic [N-1:0] pat(input int k);
        logic [N-1:0] v = '0;
        for (int i = 0; i < N; i++) begin
            if (k <= N) v[i] = (i >= N - k);
            else        v[i] = (i < N - (k - N));
        end
        return v;
    endfunction

    function automatic logic [LINES-1:0] line_of(input int k, input logic pl);
        logic [LINES-1:0] v = '0;
        v[k] = 1'b1;
        return pl ? ~v : v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic poke(input logic [N-1:0] v);
        force u0.u_ring.ring_q = v;
        #1;
        release u0.u_ring.ring_q;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // Table walk: clear, full 2N wrap (R3), polarity rows, mid-sequence clear.
        for (int i = 0; i < NROWS; i++) begin
            clr_n   = VEC[i][7];
            pol_low = VEC[i][6];
            step();
            check(i == 0 ? "R1 reset" : "R2/R3 count", 32'(cnt), 32'(pat(int'(VEC[i][5:0]))));
            check("R4/R5/R7 decode", 32'(dec), 32'(line_of(int'(VEC[i][5:0]), pol_low)));
            check("R6 one line", 32'($countones(pol_low ? ~dec : dec)), 32'd1);
        end

        // R7/R9: polarity change between edges, count untouched.
        pol_low = 1'b1;
        #2;
        check("R7 async polarity", 32'(dec), 32'(line_of(3, 1'b1)));
        check("R9 count held", 32'(cnt), 32'(pat(3)));
        pol_low = 1'b0;
        #2;
        check("R9 decode follows", 32'(dec), 32'(line_of(3, 1'b0)));

        // R1: clear held low for several edges.
        clr_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step();
            check("R1 clear held", 32'(cnt), 32'd0);
        end
        clr_n = 1'b1;
        step();
        check("R5 second state", 32'(cnt), 32'(pat(1)));
        check("R5 line 1", 32'(dec), 32'(line_of(1, 1'b0)));
        step();

        // R8: illegal pattern 10100101 recovers to zeros, then counts on.
        poke(8'hA5);
        step();
        check("R8 recover A5", 32'(cnt), 32'd0);
        step();
        check("R8 resume", 32'(cnt), 32'(pat(1)));
        step();

        // R8: lone one below the top is illegal too.
        poke(8'h40);
        step();
        check("R8 recover 40", 32'(cnt), 32'd0);
        step();
        step();

        // R8: a legal forced state is never redirected.
        poke(8'hFC);
        step();
        check("R8 legal kept", 32'(cnt), 32'(pat(7)));
        check("R5 line 7", 32'(dec), 32'(line_of(7, 1'b0)));
        step();
        check("R4 all ones", 32'(dec), 32'(line_of(N, 1'b0)));
        step();
        check("R5 zero fill", 32'(dec), 32'(line_of(N + 1, 1'b0)));

        // R1: clear overrides an illegal pattern.
        clr_n = 1'b0;
        poke(8'h5A);
        step();
        check("R1 clear over illegal", 32'(cnt), 32'd0);
        check("R4 zero line", 32'(dec), 32'(line_of(0, 1'b0)));
        clr_n = 1'b1;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule